// File: doc/BRIEF.md
# SDRAM Auto-Refresh Timer and Sequencer

This block schedules periodic auto-refresh for an SDRAM controller. A 16-bit configuration register sets the refresh count, the recovery code and three control bits. A divide-by-16 prescaler feeds a programmable counter. Together they signal that a refresh is due once every (count + 1) × 16 bus clocks. Due refreshes wait in a small backlog until the access arbiter reports the bus idle.

For each refresh, the sequencer pulses a refresh command for one clock. It then holds the activate-allowed output low for a recovery time selected by a 2-bit code. While the self-refresh bit is set, periodic refresh is suppressed. Clearing the bit schedules exactly one catch-up refresh.

The register resets to 0x0026. At a 40 MHz bus clock this gives 624 clocks between refreshes, which keeps 4096 rows within a 64 ms retention period. The recovery code in that reset value selects 3 clocks.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, the register reads 0x0026, `act_ok` is 1, and `rfsh_cmd`, `rfsh_req` and `self_rfsh` are all 0.
- R2: Register bits 15 and 14 always read 0. Bit 13 drives `ext_mux`, bit 12 drives `cke_cmd` and bit 11 drives `self_rfsh`.
- R3: With `bus_idle` held at 1, `rfsh_cmd` pulses once every (bits 8..0 + 1) × 16 clocks. The first pulse follows a register write by that number of clocks plus one.
- R4: Bits 10..9 select the recovery time: code 0 gives 3 clocks, 1 gives 6, 2 gives 9 and 3 gives 9. `act_ok` is low in the `rfsh_cmd` cycle and stays low for exactly that many cycles in total.
- R5: `rfsh_cmd` lasts one cycle. It only follows a clock in which `bus_idle` was 1.
- R6: At most two refreshes are held pending. Further expiries while two are pending are discarded.
- R7: An interval expiry in the same cycle that a pending refresh is issued is still counted.
- R8: While bit 11 is 1, `rfsh_req` and `rfsh_cmd` stay 0. A write that clears bit 11 produces exactly one `rfsh_cmd`, in the cycle after the write.
- R9: Any register write restarts the prescaler and counter, so the new interval is timed from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register contents |
| bus_idle | input | 1 | Arbiter reports the SDRAM bus free |
| rfsh_req | output | 1 | Refresh pending and sequencer ready, asks for the bus |
| rfsh_cmd | output | 1 | One-cycle auto-refresh command |
| act_ok | output | 1 | Row activation permitted |
| self_rfsh | output | 1 | Self-refresh requested |
| ext_mux | output | 1 | 1 selects external address multiplexing |
| cke_cmd | output | 1 | 1 selects the clock-enable pin as a command bit |

## Verification
An interval expiry can fall in the same cycle that the sequencer issues a waiting refresh. In that cycle the backlog must take the increment and the decrement together. The bench provokes this with a 16-clock interval and the bus held busy across two expiries, so the backlog fills. It then releases the bus exactly in the cycle of the third expiry. It judges the result by counting commands over the following interval: three are expected, where losing the coincident expiry would give two.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int CFG_W = 16;
  localparam int CNT_W = 9;
  localparam int PRE_W = 4;
  localparam int GAP_W = 4;
  localparam int PEND_W = 2;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0026;
  localparam logic [CFG_W-1:0] CFG_MASK = 16'h3FFF;

  localparam int BIT_EXTMUX = 13;
  localparam int BIT_CKECMD = 12;
  localparam int BIT_SELF = 11;
  localparam int GAP_HI = 10;
  localparam int GAP_LO = 9;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_RECOV
  } seq_state_t;

  function automatic logic [GAP_W-1:0] gap_clocks(input logic [1:0] code);
    case (code)
      2'd0:    gap_clocks = 4'd3;
      2'd1:    gap_clocks = 4'd6;
      default: gap_clocks = 4'd9;
    endcase
  endfunction

  function automatic logic [PEND_W-1:0] backlog_next(input logic [PEND_W-1:0] cur,
                                                     input logic up, input logic down,
                                                     input logic [PEND_W-1:0] cap);
    logic [PEND_W:0] sum;
    sum = {1'b0, cur} + {{PEND_W{1'b0}}, up};
    if (down && sum != '0) sum = sum - 1'b1;
    if (sum > {1'b0, cap}) sum = {1'b0, cap};
    backlog_next = sum[PEND_W-1:0];
  endfunction
endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
  parameter int PRE_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_LAST);
  assign expire = pre_wrap && (cnt_q == limit) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap) begin
        if (cnt_q == limit) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog
  import rfsh_pkg::*;
#(
  parameter int MAX_PEND = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  input  logic              clr,
  input  logic              set_one,
  output logic [PEND_W-1:0] pend
);
  localparam logic [PEND_W-1:0] CAP = PEND_W'(MAX_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else if (set_one) pend <= PEND_W'(1);
    else if (clr) pend <= '0;
    else pend <= backlog_next(pend, inc, dec, CAP);
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_nz,
  input  logic       bus_idle,
  input  logic       self_on,
  input  logic       hold,
  input  logic [1:0] gap_code,
  output logic       rfsh_req,
  output logic       issue,
  output logic       rfsh_cmd,
  output logic       act_ok
);
  seq_state_t       state_q;
  logic [GAP_W-1:0] gap_q;

  assign rfsh_req = (state_q == SEQ_IDLE) && pend_nz && !self_on;
  assign issue = rfsh_req && bus_idle && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      gap_q    <= '0;
      rfsh_cmd <= 1'b0;
      act_ok   <= 1'b1;
    end else begin
      rfsh_cmd <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (issue) begin
            state_q  <= SEQ_RECOV;
            gap_q    <= gap_clocks(gap_code) - 1'b1;
            rfsh_cmd <= 1'b1;
            act_ok   <= 1'b0;
          end
        end
        default: begin
          if (gap_q == '0) begin
            state_q <= SEQ_IDLE;
            act_ok  <= 1'b1;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             bus_idle,
  output logic             rfsh_req,
  output logic             rfsh_cmd,
  output logic             act_ok,
  output logic             self_rfsh,
  output logic             ext_mux,
  output logic             cke_cmd
);
  logic [CFG_W-1:0]  cfg_q;
  logic              tmr_expire;
  logic              seq_issue;
  logic [PEND_W-1:0] pend_cnt;
  logic              sr_exit;
  logic              sr_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_wdata & CFG_MASK;
  end

  assign cfg_rdata = cfg_q;
  assign self_rfsh = cfg_q[BIT_SELF];
  assign ext_mux   = cfg_q[BIT_EXTMUX];
  assign cke_cmd   = cfg_q[BIT_CKECMD];

  assign sr_exit = cfg_we && cfg_q[BIT_SELF] && !cfg_wdata[BIT_SELF];
  assign sr_hold = cfg_q[BIT_SELF] || (cfg_we && cfg_wdata[BIT_SELF]);

  rfsh_tick #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(cfg_we),
    .limit  (cfg_q[CNT_W-1:0]),
    .expire (tmr_expire)
  );

  rfsh_backlog #(.MAX_PEND(2)) i_backlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (tmr_expire && !cfg_q[BIT_SELF]),
    .dec    (seq_issue),
    .clr    (sr_hold),
    .set_one(sr_exit),
    .pend   (pend_cnt)
  );

  rfsh_seq i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_nz (pend_cnt != '0),
    .bus_idle(bus_idle),
    .self_on (cfg_q[BIT_SELF]),
    .hold    (cfg_we),
    .gap_code(cfg_q[GAP_HI:GAP_LO]),
    .rfsh_req(rfsh_req),
    .issue   (seq_issue),
    .rfsh_cmd(rfsh_cmd),
    .act_ok  (act_ok)
  );
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       bus_idle,
  input logic       rfsh_req,
  input logic       rfsh_cmd,
  input logic       act_ok,
  input logic       self_rfsh,
  input logic       tmr_expire,
  input logic       seq_issue,
  input logic [1:0] pend_cnt
);
  logic [3:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!act_ok) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_cmd |=> !rfsh_cmd); // R5
  AST_CMD_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_cmd |-> $past(bus_idle)); // R5
  AST_ACT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_cmd |-> !act_ok); // R4
  AST_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_ok) |-> (low_run >= 4'd3 && low_run <= 4'd9)); // R4
  AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= 2'd2); // R6
  AST_SELF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    self_rfsh |-> (!rfsh_req && !rfsh_cmd)); // R8
  AST_EXPIRE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire && !seq_issue && !cfg_we && !self_rfsh && pend_cnt == 2'd1)
      |=> pend_cnt == 2'd2); // R6
  AST_COINCIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expire && seq_issue && !cfg_we && pend_cnt == 2'd2)
      |=> pend_cnt == 2'd2); // R7
endmodule

bind rfsh_sched rfsh_sched_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .bus_idle  (bus_idle),
  .rfsh_req  (rfsh_req),
  .rfsh_cmd  (rfsh_cmd),
  .act_ok    (act_ok),
  .self_rfsh (self_rfsh),
  .tmr_expire(tmr_expire),
  .seq_issue (seq_issue),
  .pend_cnt  (pend_cnt)
);

// File: tb/test_rfsh_sched.sv
module test_rfsh_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        bus_idle = 1'b1;
  logic        rfsh_req, rfsh_cmd, act_ok, self_rfsh, ext_mux, cke_cmd;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rfsh_sched i_rfsh_sched (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_idle(bus_idle), .rfsh_req(rfsh_req),
    .rfsh_cmd(rfsh_cmd), .act_ok(act_ok), .self_rfsh(self_rfsh),
    .ext_mux(ext_mux), .cke_cmd(cke_cmd)
  );

  // rc field, recovery code, expected interval, expected low cycles
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{0,    0, 16,  3},
    '{1,    1, 32,  6},
    '{2,    2, 48,  9},
    '{0,    3, 16,  9},
    '{38,   0, 624, 3}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns at the negedge following the write edge
  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_cmd(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!rfsh_cmd && k < 2000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int k, k2, low, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", cfg_rdata, 16'h0026);
    check("R1 act_ok", act_ok, 1);
    check("R1 rfsh_cmd", rfsh_cmd, 0);
    check("R1 rfsh_req", rfsh_req, 0);
    check("R1 self_rfsh", self_rfsh, 0);

    // R2: bits 15:14 read zero, 13/12/11 to outputs
    wr(16'hFFFF);
    check("R2 rdata", cfg_rdata, 16'h3FFF);
    check("R2 ext_mux", ext_mux, 1);
    check("R2 cke_cmd", cke_cmd, 1);
    check("R2 self_rfsh", self_rfsh, 1);
    wr(16'h0000);
    check("R2 clear", {29'd0, ext_mux, cke_cmd, self_rfsh}, 0);
    repeat (20) @(negedge clk);

    // R3/R4 table: interval and recovery per setting
    for (int v = 0; v < NV; v++) begin
      wr(16'((VEC[v][1] << 9) | VEC[v][0]));
      wait_cmd(k);
      check("R3 first cmd after write", k, VEC[v][2] + 1);
      low = 0;
      while (!act_ok && low < 20) begin
        low++;
        @(negedge clk);
      end
      check("R4 act_ok low cycles", low, VEC[v][3]);
      wait_cmd(k2);
      check("R3 interval", k2 + low, VEC[v][2]);
    end

    // R9: rewrite mid-interval restarts timing
    wr(16'h0000);
    repeat (10) @(negedge clk);
    wr(16'h0001);
    wait_cmd(k);
    check("R9 restart after rewrite", k, 33);

    // R8: self-refresh suppresses, exit gives one refresh next cycle
    wr(16'h0800);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      cnt += int'(rfsh_cmd) + int'(rfsh_req);
    end
    check("R8 quiet in self-refresh", cnt, 0);
    wr(16'h0000);
    check("R8 no cmd on write cycle", rfsh_cmd, 0);
    @(negedge clk);
    check("R8 exit cmd", rfsh_cmd, 1);
    cnt = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      cnt += int'(rfsh_cmd);
    end
    check("R8 single exit refresh", cnt, 0);
    repeat (20) @(negedge clk);

    // R7: expiry coincides with issue while backlog holds two
    bus_idle = 1'b0;
    wr(16'h0000);
    repeat (47) @(negedge clk);
    bus_idle = 1'b1;
    cnt = 0;
    for (int i = 48; i < 64; i++) begin
      @(negedge clk);
      cnt += int'(rfsh_cmd);
    end
    check("R7 coincident expiry kept", cnt, 3);
    repeat (40) @(negedge clk);

    // R6: backlog saturates at two
    bus_idle = 1'b0;
    wr(16'h0000);
    repeat (20) @(negedge clk);
    check("R6 req while bus busy", rfsh_req, 1);
    repeat (64) @(negedge clk);
    bus_idle = 1'b1;
    cnt = 0;
    for (int i = 85; i < 96; i++) begin
      @(negedge clk);
      cnt += int'(rfsh_cmd);
    end
    check("R6 backlog cap", cnt, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule